// File: doc/BRIEF.md
# Clocked-Slave Serial Transmitter with Holding Stage

This block sends words out on a serial data line, using a shift clock that an external master drives. The host pushes words through a valid/ready write port. A word written while the shifter is idle goes straight into the shifter. A word written while the shifter is busy waits in a one-entry holding stage and moves into the shifter once the previous frame's last bit has been sampled. The ready flag reports whether the holding stage is free. When its enable bit is set, the flag also drives an interrupt line that doubles as a wake request.

The block is gated by a set of plain control pins: port enable, synchronous select, clock-source select (0 selects slave operation), transmit enable, the two receive enables, a 9-bit frame enable and the ninth-bit value. Data changes on the falling edge of the serial clock and stays stable across the rising edge, where the master samples it. In normal operation the serial clock passes through a multi-flop synchronizer. While the core is asleep, a one-register direct path detects the edges instead. In that mode the shifter keeps running and the wake line can rise.

Top module: `cst_slave_tx`

## Requirements
- R1: After reset the data line is 1, the ready flag is 1, the interrupt line is 0 and, with all controls at 0, the write port reports not ready.
- R2: The write port is ready only when the port is enabled, synchronous select is 1, clock-source select is 0, transmit enable is 1, both receive enables are 0, the core is not asleep and the holding stage is empty. A word transfers on a cycle where valid and ready are both 1; while ready is 0 the host must hold the word.
- R3: A word accepted while the shifter is idle goes directly into the shifter, and the ready flag stays 1.
- R4: A word accepted while the shifter is busy stays in the holding stage, and the ready flag reads 0 until that word moves on.
- R5: Each falling serial-clock edge drives the next bit, least significant bit first (bit 0 before bit 7). The line does not change on rising edges.
- R6: After the rising edge that samples a frame's last bit, a held word moves into the shifter and the ready flag returns to 1.
- R7: With the 9-bit enable at 1 when a word is accepted, the ninth-bit value captured with it is sent as a ninth bit after bit 7.
- R8: The interrupt/wake line equals the ready flag while the interrupt enable is 1, and is 0 while the interrupt enable is 0.
- R9: Clearing transmit enable or port enable empties both the holding stage and the shifter, stops shifting and sets the ready flag. The data line keeps its last value.
- R10: While asleep the write port refuses words, but the shifter keeps sending on serial-clock edges detected through the direct path, and the held word still moves on.
- R11: While no frame is in progress, serial-clock edges leave the data line unchanged.
- R12: Setting clock-source select or either receive enable makes the transmitter inactive, which has the same effect as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_sleep | input | 1 | 1 while the core is asleep; selects the direct edge path |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock-source select; 0 = slave |
| tx_en | input | 1 | Transmit enable |
| rx_cont_en | input | 1 | Continuous receive enable (must be 0) |
| rx_single_en | input | 1 | Single receive enable (must be 0) |
| nine_en | input | 1 | 9-bit frame enable, captured with each word |
| ninth_bit | input | 1 | Ninth bit value, captured with each word |
| ready_irq_en | input | 1 | Interrupt enable for the ready flag |
| wr_valid | input | 1 | Host word valid |
| wr_ready | output | 1 | Write port ready |
| wr_data | input | DATA_W | Host word |
| sck | input | 1 | External shift clock, idle high |
| sdo | output | 1 | Serial data out |
| tx_ready | output | 1 | Holding stage empty flag |
| irq_wake | output | 1 | Interrupt / wake request |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2, so both 8-bit and 9-bit frames and the extra synchronizer latency show up in a short run. It switches the edge path in the middle of a test by putting the core to sleep while a word is held, so the hand-off from the holding stage is also seen on the direct path. A behavioural model updated on every serial-clock edge predicts the data line, both ready signals and the wake line. It also covers flushes in mid-frame and idle clocking.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic {
    EDGE_SYNC   = 1'b0,
    EDGE_DIRECT = 1'b1
  } edge_path_e;

  function automatic int unsigned cnt_width(input int unsigned data_w);
    return $clog2(data_w + 2);
  endfunction
endpackage

// File: rtl/cst_edge_det.sv
module cst_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  cst_pkg::edge_path_e path_i,
  output logic              fall_o,
  output logic              rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;
  logic                   s_fall, s_rise, d_fall, d_rise;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sck_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev_q <= 1'b1;
      raw_prev_q  <= 1'b1;
    end else begin
      sync_prev_q <= sync_q[LAST];
      raw_prev_q  <= sck_i;
    end
  end

  always_comb begin
    s_fall = sync_prev_q & ~sync_q[LAST];
    s_rise = ~sync_prev_q & sync_q[LAST];
    d_fall = raw_prev_q & ~sck_i;
    d_rise = ~raw_prev_q & sck_i;
    fall_o = (path_i == cst_pkg::EDGE_DIRECT) ? d_fall : s_fall;
    rise_o = (path_i == cst_pkg::EDGE_DIRECT) ? d_rise : s_rise;
  end
endmodule

// File: rtl/cst_hold.sv
module cst_hold #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              put_i,
  input  logic [WORD_W-1:0] put_word_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      word_o <= '0;
    end else if (flush_i) begin
      full_o <= 1'b0;
    end else if (put_i) begin
      full_o <= 1'b1;
      word_o <= put_word_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cst_shift.sv
module cst_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            load_i,
  input  logic [DATA_W+1:0] load_word_i,
  input  logic            fall_i,
  input  logic            rise_i,
  output logic            idle_o,
  output logic            sdo_o
);
  localparam int unsigned CNT_W = cst_pkg::cnt_width(DATA_W);
  localparam logic [CNT_W-1:0] LEN8 = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LEN9 = CNT_W'(DATA_W + 1);

  logic [DATA_W:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign idle_o = (cnt_q == '0) && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      sdo_o  <= 1'b1;
    end else if (flush_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= load_word_i[DATA_W:0];
      cnt_q <= load_word_i[DATA_W+1] ? LEN9 : LEN8;
    end else if (fall_i && cnt_q != '0) begin
      sdo_o  <= sh_q[0];
      sh_q   <= {1'b0, sh_q[DATA_W:1]};
      cnt_q  <= cnt_q - 1'b1;
      pend_q <= 1'b1;
    end else if (rise_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cst_slave_tx.sv
module cst_slave_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_sleep,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_master,
  input  logic              tx_en,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              nine_en,
  input  logic              ninth_bit,
  input  logic              ready_irq_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sck,
  output logic              sdo,
  output logic              tx_ready,
  output logic              irq_wake
);
  localparam int unsigned WORD_W = DATA_W + 2;

  logic              active, accept, sh_idle, hold_full;
  logic              sh_load, hold_put, hold_take, fall, rise;
  logic [WORD_W-1:0] in_word, hold_word, load_word;
  cst_pkg::edge_path_e path;

  assign path    = core_sleep ? cst_pkg::EDGE_DIRECT : cst_pkg::EDGE_SYNC;
  assign active  = port_en & sync_mode & ~clk_master & tx_en & ~rx_cont_en & ~rx_single_en;
  assign wr_ready = active & ~hold_full & ~core_sleep;
  assign accept  = wr_valid & wr_ready;
  assign in_word = {nine_en, ninth_bit, wr_data};

  assign hold_take = active & hold_full & sh_idle;
  assign hold_put  = accept & ~sh_idle;
  assign sh_load   = hold_take | (accept & sh_idle);
  assign load_word = hold_full ? hold_word : in_word;

  assign tx_ready = ~hold_full;
  assign irq_wake = tx_ready & ready_irq_en;

  cst_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck),
    .path_i (path),
    .fall_o (fall),
    .rise_o (rise)
  );

  cst_hold #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (~active),
    .put_i      (hold_put),
    .put_word_i (in_word),
    .take_i     (hold_take),
    .full_o     (hold_full),
    .word_o     (hold_word)
  );

  cst_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (~active),
    .load_i      (sh_load),
    .load_word_i (load_word),
    .fall_i      (fall),
    .rise_i      (rise),
    .idle_o      (sh_idle),
    .sdo_o       (sdo)
  );
endmodule

// File: rtl/cst_slave_tx_chk.sv
module cst_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic core_sleep,
  input logic port_en,
  input logic tx_en,
  input logic ready_irq_en,
  input logic wr_valid,
  input logic wr_ready,
  input logic sdo,
  input logic tx_ready,
  input logic irq_wake,
  input logic shift_idle
);
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!core_sleep && tx_ready)); // R2

  AST_DIRECT_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && shift_idle) |=> tx_ready); // R3

  AST_QUEUE_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !shift_idle && port_en && tx_en) |=> !tx_ready); // R4

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_irq_en |-> !irq_wake); // R8

  AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && tx_en) |=> tx_ready); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_idle |=> $stable(sdo)); // R11
endmodule

bind cst_slave_tx cst_slave_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_sleep   (core_sleep),
  .port_en      (port_en),
  .tx_en        (tx_en),
  .ready_irq_en (ready_irq_en),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .sdo          (sdo),
  .tx_ready     (tx_ready),
  .irq_wake     (irq_wake),
  .shift_idle   (sh_idle)
);

// File: tb/cst_slave_tx_test.sv
module cst_slave_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int SETTLE     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_sleep = 0, port_en = 0, sync_mode = 0, clk_master = 0, tx_en = 0;
  logic rx_cont_en = 0, rx_single_en = 0, nine_en = 0, ninth_bit = 0, ready_irq_en = 0;
  logic wr_valid = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic sck = 1'b1;
  logic wr_ready, sdo, tx_ready, irq_wake;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference model
  int m_cnt = 0, m_pend = 0, m_sh = 0, m_sdo = 1;
  int m_hfull = 0, m_hword = 0, m_his9 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cst_slave_tx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .core_sleep(core_sleep), .port_en(port_en),
    .sync_mode(sync_mode), .clk_master(clk_master), .tx_en(tx_en),
    .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en), .nine_en(nine_en),
    .ninth_bit(ninth_bit), .ready_irq_en(ready_irq_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .sck(sck), .sdo(sdo),
    .tx_ready(tx_ready), .irq_wake(irq_wake)
  );

  function automatic bit m_active();
    return port_en && sync_mode && !clk_master && tx_en && !rx_cont_en && !rx_single_en;
  endfunction

  function automatic void m_settle();
    if (!m_active()) begin
      m_cnt = 0; m_pend = 0; m_hfull = 0;
    end else if (m_hfull != 0 && m_cnt == 0 && m_pend == 0) begin
      m_sh = m_hword; m_cnt = (m_his9 != 0) ? DATA_W + 1 : DATA_W; m_hfull = 0;
    end
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "sdo", sdo, m_sdo[0]);
    chk(req, "tx_ready", tx_ready, (m_hfull == 0));
    chk(req, "wr_ready", wr_ready, m_active() && m_hfull == 0 && !core_sleep);
    chk(req, "irq_wake", irq_wake, (m_hfull == 0) && ready_irq_en);
  endtask

  task automatic wait_settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic ctrl_update(string req);
    m_settle();
    wait_settle();
    m_settle();
    chk_all(req);
  endtask

  task automatic write_word(string req, int data, bit n9, bit nb);
    @(negedge clk);
    wr_valid = 1; wr_data = DATA_W'(data); nine_en = n9; ninth_bit = nb;
    @(negedge clk);
    wr_valid = 0;
    if (m_active() && m_hfull == 0 && !core_sleep) begin
      if (m_cnt == 0 && m_pend == 0) begin
        m_sh = data | (int'(nb) << DATA_W); m_cnt = n9 ? DATA_W + 1 : DATA_W;
      end else begin
        m_hfull = 1; m_hword = data | (int'(nb) << DATA_W); m_his9 = n9;
      end
    end
    wait_settle();
    chk_all(req);
  endtask

  task automatic sck_fall(string req);
    @(negedge clk);
    sck = 0;
    if (m_cnt > 0) begin
      m_sdo = m_sh & 1; m_sh = m_sh >> 1; m_cnt--; m_pend = 1;
    end
    m_settle();
    wait_settle();
    chk_all(req);
  endtask

  task automatic sck_rise(string req);
    @(negedge clk);
    sck = 1;
    m_pend = 0;
    m_settle();
    wait_settle();
    chk_all(req);
  endtask

  task automatic shift_frame(string req, int nbits, output int got);
    got = 0;
    for (int i = 0; i < nbits; i++) begin
      sck_fall(req);
      got = got | (int'(sdo) << i);
      sck_rise(req);
    end
  endtask

  int got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "sdo", sdo, 1'b1);
    chk("R1", "tx_ready", tx_ready, 1'b1);
    chk("R1", "irq_wake", irq_wake, 1'b0);
    chk("R1", "wr_ready", wr_ready, 1'b0);

    // R2: enable slave transmission
    port_en = 1; sync_mode = 1; clk_master = 0; tx_en = 1;
    ctrl_update("R2");
    chk("R2", "wr_ready enabled", wr_ready, 1'b1);

    // R3 direct load, R4 queued word
    write_word("R3", 'hA5, 0, 0);
    chk("R3", "ready after direct load", tx_ready, 1'b1);
    write_word("R4", 'h3C, 0, 0);
    chk("R4", "ready with held word", tx_ready, 1'b0);
    chk("R4", "wr_ready with held word", wr_ready, 1'b0);

    // R5 LSB first, R6 hand-off
    shift_frame("R5", DATA_W, got);
    chk("R5", "frame A5 bits", got == 'hA5, 1'b1);
    chk("R6", "ready after hand-off", tx_ready, 1'b1);
    shift_frame("R6", DATA_W, got);
    chk("R6", "frame 3C bits", got == 'h3C, 1'b1);

    // R11 idle clocking leaves sdo alone
    for (int i = 0; i < 3; i++) begin
      sck_fall("R11");
      sck_rise("R11");
    end

    // R7 nine-bit frame
    write_word("R7", 'h5A, 1, 1);
    shift_frame("R7", DATA_W + 1, got);
    chk("R7", "frame 15A bits", got == 'h15A, 1'b1);
    nine_en = 0; ninth_bit = 0;

    // R8 interrupt follows ready
    ready_irq_en = 1;
    ctrl_update("R8");
    chk("R8", "irq with ready", irq_wake, 1'b1);
    write_word("R8", 'h81, 0, 0);
    write_word("R8", 'h7E, 0, 0);
    chk("R8", "irq while held", irq_wake, 1'b0);

    // R10 sleep: direct path keeps shifting, writes refused
    core_sleep = 1;
    ctrl_update("R10");
    chk("R10", "wr_ready asleep", wr_ready, 1'b0);
    shift_frame("R10", DATA_W, got);
    chk("R10", "frame 81 asleep", got == 'h81, 1'b1);
    chk("R10", "wake after hand-off", irq_wake, 1'b1);
    shift_frame("R10", DATA_W, got);
    chk("R10", "frame 7E asleep", got == 'h7E, 1'b1);
    core_sleep = 0;
    ctrl_update("R10");

    // R9 flush in mid-frame by transmit enable
    write_word("R9", 'hF0, 0, 0);
    write_word("R9", 'h0F, 0, 0);
    for (int i = 0; i < 3; i++) begin
      sck_fall("R9");
      sck_rise("R9");
    end
    tx_en = 0;
    ctrl_update("R9");
    chk("R9", "ready after flush", tx_ready, 1'b1);
    sck_fall("R9");
    sck_rise("R9");
    tx_en = 1;
    ctrl_update("R9");
    write_word("R9", 'h96, 0, 0);
    shift_frame("R9", DATA_W, got);
    chk("R9", "fresh frame after flush", got == 'h96, 1'b1);

    // R9 flush by port enable
    write_word("R9", 'h11, 0, 0);
    write_word("R9", 'h22, 0, 0);
    port_en = 0;
    ctrl_update("R9");
    port_en = 1;
    ctrl_update("R9");

    // R12 other controls make it inactive
    write_word("R12", 'h44, 0, 0);
    write_word("R12", 'h55, 0, 0);
    rx_cont_en = 1;
    ctrl_update("R12");
    chk("R12", "wr_ready with receive on", wr_ready, 1'b0);
    rx_cont_en = 0;
    ctrl_update("R12");
    rx_single_en = 1;
    ctrl_update("R12");
    rx_single_en = 0;
    clk_master = 1;
    ctrl_update("R12");
    chk("R12", "wr_ready as clock master", wr_ready, 1'b0);
    clk_master = 0;
    ctrl_update("R12");
    write_word("R12", 'hC3, 0, 0);
    shift_frame("R12", DATA_W, got);
    chk("R12", "frame after re-enable", got == 'hC3, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule